// File: doc/BRIEF.md
# Full-Period Shift-Register Sequence Generator

This block produces a pseudo-random bit stream and state word from a shift register with linear feedback, extended so that its cycle runs through every one of the 2^W states of a W-bit register. A plain maximal-length generator skips one state, so its period is odd and its output bit carries one more value of one kind than the other. Here a detector watches for the state next to the skipped one and flips the feedback bit. That routes the sequence into the skipped state for one step and straight back out, which makes the period even and the output bit exactly balanced.

The state moves one step on each clock edge where the step enable is high. A seed load writes any value, including the otherwise skipped one, and takes priority over stepping. Consumers may use the whole state word or the single serial bit. The width is a parameter. Feedback tap sets are built in for widths 3 to 8, 16 and 32.

Top module: `fp_lfsr`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets the state to all zeros, so state reads 0 and out_bit reads 0 after that edge.
- R2: On an edge with step_en high and seed_load low, the state shifts left by one. Bit 0 takes the XNOR of the tap bits, inverted when state bits W-2..0 are all ones. The taps are bits 3,2 for W=4 and bits 7,3,2,1 for W=8.
- R3: On an edge with both step_en and seed_load low, the state keeps its value.
- R4: On an edge with seed_load high, the state takes the value of seed whatever step_en is.
- R5: For W=4, stepping from 0000 visits 0000, 0001, 0011, 0111, 1111, 1110, 1101, 1011, 0110, 1100, 1001, 0010, 0101, 1010, 0100, 1000 in that order and then returns to 0000.
- R6: Stepping 2^W times from any state visits each of the 2^W states exactly once and returns to the starting state (checked for W=4 and W=8).
- R7: out_bit equals state bit W-1. Over one full period it is one in exactly 2^(W-1) of the states.
- R8: The all-ones state is not a lockup: a step from all ones gives all ones with bit 0 cleared, and a step from a zero MSB followed by all ones gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the sequence one step at this edge |
| seed_load | input | 1 | Load seed into the state at this edge (overrides step_en) |
| seed | input | WIDTH | Value written on a seed load |
| state | output | WIDTH | Current register contents |
| out_bit | output | 1 | Serial output, the register MSB |

## Verification
Every result of this block is due one rising edge after its stimulus: a step, a hold, a seed load and a reset all show on state at the first edge where the input is seen. out_bit follows state in the same cycle, since no register lies between them. The bench changes inputs on the falling edge, lets exactly one rising edge pass, clears the controls and samples 1 ns later. It keeps a step count of its own, so each sample lines up with one known transition. Period and balance checks come from a table of visited states kept in the bench, not from the design's internals.

// File: rtl/fp_lfsr_pkg.sv
// Package fp_lfsr_pkg
// Shared constants and the table of feedback tap masks. A mask has bit i set
// when register bit i feeds the XNOR. Every listed mask gives a maximal
// (2^W - 1) cycle in left-shift form with XNOR feedback. Widths not listed
// return zero, and the top module rejects them at elaboration.
package fp_lfsr_pkg;

    localparam int MAX_WIDTH = 32;
    localparam int MIN_WIDTH = 3;

    // Returns the tap mask for a register of the given width.
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
        logic [MAX_WIDTH-1:0] m;
        m = '0;
        case (width)
            3:  begin m[2] = 1'b1; m[1] = 1'b1; end
            4:  begin m[3] = 1'b1; m[2] = 1'b1; end
            5:  begin m[4] = 1'b1; m[2] = 1'b1; end
            6:  begin m[5] = 1'b1; m[4] = 1'b1; end
            7:  begin m[6] = 1'b1; m[5] = 1'b1; end
            8:  begin m[7] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[1] = 1'b1; end
            16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
            32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fp_lfsr_tap_net.sv
// Module fp_lfsr_tap_net
// Forms the plain feedback bit as the XNOR of the register bits chosen by
// TAP_MASK. Purely combinational. Assumes TAP_MASK has at least two bits set,
// and that bit WIDTH-1 is among them, so that all ones is the only lockup
// state of the plain loop.
module fp_lfsr_tap_net #(
    parameter int               WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAP_MASK = '0
) (
    input  logic [WIDTH-1:0] cur_state,
    output logic             fb_plain
);

    logic [WIDTH-1:0] tapped;

    // Keep only the tap positions, one gate per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (TAP_MASK[i]) begin : g_on
            assign tapped[i] = cur_state[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    // XNOR reduction of the kept bits.
    always_comb begin
        fb_plain = ~(^tapped);
    end

endmodule

// File: rtl/fp_lfsr_lockup_gate.sv
// Module fp_lfsr_lockup_gate
// Extends the cycle to cover the all-ones state. When the low WIDTH-1 bits
// are all ones, the state is either 0111..1 or 1111..1. Flipping the plain
// feedback then sends 0111..1 into 1111..1 and 1111..1 on to 1111..10,
// which joins the skipped state into the cycle. Assumes XNOR feedback with
// the MSB as a tap.
module fp_lfsr_lockup_gate #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-2:0] low_bits,
    input  logic             fb_plain,
    output logic             fb_ext,
    output logic             near_lockup
);

    // Detect the pattern next to the lockup state.
    always_comb begin
        near_lockup = &low_bits;
    end

    // Invert the feedback bit while the pattern is present.
    always_comb begin
        fb_ext = fb_plain ^ near_lockup;
    end

endmodule

// File: rtl/fp_lfsr_state_reg.sv
// Module fp_lfsr_state_reg
// Holds the sequence state. Priority on each edge: reset, then seed load,
// then step, else hold. A step shifts left and puts the feedback bit in bit 0.
module fp_lfsr_state_reg #(
    parameter int               WIDTH       = 4,
    parameter logic [WIDTH-1:0] RESET_STATE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed,
    input  logic             fb_in,
    output logic [WIDTH-1:0] state_q
);

    logic [WIDTH-1:0] state_d;

    // Select the next state from the control inputs.
    always_comb begin
        if (seed_load) begin
            state_d = seed;
        end else if (step_en) begin
            state_d = {state_q[WIDTH-2:0], fb_in};
        end else begin
            state_d = state_q;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/fp_lfsr.sv
// Module fp_lfsr
// Full-period shift-register sequence generator. Its 2^WIDTH cycle includes
// the all-ones state, so out_bit is one in exactly half of the states.
// Assumes WIDTH has a tap set in fp_lfsr_pkg. Other widths stop elaboration.
module fp_lfsr #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state,
    output logic             out_bit
);

    localparam logic [fp_lfsr_pkg::MAX_WIDTH-1:0] TAP_ALL  = fp_lfsr_pkg::tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]                  TAP_MASK = TAP_ALL[WIDTH-1:0];
    localparam logic [WIDTH-1:0]                  RST_VAL  = '0;

    // Reject widths with no tap set or outside the supported range.
    if (WIDTH < fp_lfsr_pkg::MIN_WIDTH || WIDTH > fp_lfsr_pkg::MAX_WIDTH || TAP_ALL == '0) begin : g_bad_width
        $error("fp_lfsr: no tap set for WIDTH=%0d", WIDTH);
    end

    logic fb_plain;
    logic fb_ext;
    logic near_lockup;

    fp_lfsr_tap_net #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) tap_i (
        .cur_state (state),
        .fb_plain  (fb_plain)
    );

    fp_lfsr_lockup_gate #(
        .WIDTH (WIDTH)
    ) gate_i (
        .low_bits    (state[WIDTH-2:0]),
        .fb_plain    (fb_plain),
        .fb_ext      (fb_ext),
        .near_lockup (near_lockup)
    );

    fp_lfsr_state_reg #(
        .WIDTH       (WIDTH),
        .RESET_STATE (RST_VAL)
    ) reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .seed_load (seed_load),
        .seed      (seed),
        .fb_in     (fb_ext),
        .state_q   (state)
    );

    // Serial output: the bit about to leave the register.
    always_comb begin
        out_bit = state[WIDTH-1];
    end

endmodule

// File: rtl/fp_lfsr_checker.sv
// Module fp_lfsr_checker
// Temporal properties of fp_lfsr, attached to every instance by bind.
module fp_lfsr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed,
    input logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] ALL_ONES  = '1;
    localparam logic [WIDTH-1:0] NEAR_LOCK = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] AFTER_ALL = {{(WIDTH-1){1'b1}}, 1'b0};

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !seed_load) |=> (state == $past(state)));

    assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (state == $past(seed)));

    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

    assert_enter_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load && state == NEAR_LOCK) |=> (state == ALL_ONES));

    assert_leave_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load && state == ALL_ONES) |=> (state == AFTER_ALL));

endmodule

bind fp_lfsr fp_lfsr_checker #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .seed_load (seed_load),
    .seed      (seed),
    .state     (state)
);

// File: tb/fp_lfsr_tb_top.sv
`timescale 1ns/1ps
// Directed bench for fp_lfsr: one 4-bit instance and one 8-bit instance.
module fp_lfsr_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic       se4 = 1'b0, sl4 = 1'b0;
    logic [3:0] sd4 = '0;
    logic [3:0] st4;
    logic       ob4;

    logic       se8 = 1'b0, sl8 = 1'b0;
    logic [7:0] sd8 = '0;
    logic [7:0] st8;
    logic       ob8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp_lfsr #(.WIDTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(se4), .seed_load(sl4),
        .seed(sd4), .state(st4), .out_bit(ob4)
    );

    fp_lfsr #(.WIDTH(8)) dut_w8_i (
        .clk(clk), .rst_n(rst_n), .step_en(se8), .seed_load(sl8),
        .seed(sd8), .state(st8), .out_bit(ob8)
    );

    // Expected 4-bit order from R5.
    localparam logic [3:0] SEQ4 [16] = '{
        4'h0, 4'h1, 4'h3, 4'h7, 4'hF, 4'hE, 4'hD, 4'hB,
        4'h6, 4'hC, 4'h9, 4'h2, 4'h5, 4'hA, 4'h4, 4'h8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One edge on both instances, then controls cleared and a settle delay.
    task automatic tick(input logic e4, input logic l4, input logic [3:0] d4,
                        input logic e8, input logic l8, input logic [7:0] d8);
        @(negedge clk);
        se4 = e4; sl4 = l4; sd4 = d4;
        se8 = e8; sl8 = l8; sd8 = d8;
        @(posedge clk);
        #1;
        se4 = 1'b0; sl4 = 1'b0;
        se8 = 1'b0; sl8 = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        se4 = 1'b1; se8 = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset state w4", st4, 0);
        chk("R1 reset out_bit w4", ob4, 0);
        chk("R1 reset state w8", st8, 0);
        chk("R1 reset out_bit w8", ob8, 0);
        @(negedge clk);
        rst_n = 1'b1;
        se4 = 1'b0; se8 = 1'b0;
    endtask

    // R5 order, R6 return, R7 balance for W=4.
    task automatic t_seq4();
        int ones;
        ones = 0;
        chk("R5 start w4", st4, SEQ4[0]);
        for (int i = 1; i <= 16; i++) begin
            ones += ob4;
            tick(1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00);
            chk($sformatf("R5 step %0d w4", i), st4, SEQ4[i % 16]);
        end
        chk("R6 back to start w4", st4, 0);
        chk("R7 ones per period w4", ones, 8);
    endtask

    // R6 full coverage, R7 balance and R2 shift for W=8.
    task automatic t_period8();
        bit seen [256];
        int dups, ones, shift_err, visited;
        logic [7:0] start, prev;
        dups = 0; ones = 0; shift_err = 0; visited = 0;
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        start = st8;
        for (int i = 0; i < 256; i++) begin
            if (seen[st8]) dups++;
            seen[st8] = 1'b1;
            ones += ob8;
            if (ob8 !== st8[7]) shift_err++;
            prev = st8;
            tick(1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
            if (st8[7:1] !== prev[6:0]) shift_err++;
        end
        for (int i = 0; i < 256; i++) visited += seen[i];
        chk("R6 no repeat w8", dups, 0);
        chk("R6 all states visited w8", visited, 256);
        chk("R6 back to start w8", st8, start);
        chk("R7 ones per period w8", ones, 128);
        chk("R2 shift and R7 msb tracking w8", shift_err, 0);
    endtask

    task automatic t_hold();
        logic [3:0] h4;
        logic [7:0] h8;
        tick(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        h4 = st4; h8 = st8;
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 8'hA5);
            chk("R3 hold w4", st4, h4);
            chk("R3 hold w8", st8, h8);
        end
    endtask

    task automatic t_seed();
        tick(1'b1, 1'b1, 4'h9, 1'b1, 1'b1, 8'h3C);
        chk("R4 seed wins over step w4", st4, 4'h9);
        chk("R4 seed wins over step w8", st8, 8'h3C);
        tick(1'b0, 1'b1, 4'h6, 1'b0, 1'b1, 8'hC3);
        chk("R4 seed without step w4", st4, 4'h6);
        chk("R4 seed without step w8", st8, 8'hC3);
        // From 0x3C: taps 7,3,2,1 = 0,1,1,0 -> XNOR 1 -> 0x79 (R2)
        tick(1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h3C);
        tick(1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        chk("R2 feedback w8 from 3C", st8, 8'h79);
        tick(1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 8'hFF);
        chk("R8 all-ones seed w4", st4, 4'hF);
        chk("R7 out_bit on all ones w8", ob8, 1);
        tick(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        chk("R8 leave all ones w4", st4, 4'hE);
        chk("R8 leave all ones w8", st8, 8'hFE);
        tick(1'b0, 1'b1, 4'h7, 1'b0, 1'b1, 8'h7F);
        tick(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        chk("R8 enter all ones w4", st4, 4'hF);
        chk("R8 enter all ones w8", st8, 8'hFF);
    endtask

    task automatic t_reset_mid();
        tick(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        t_reset();
        chk("R1 reset after stepping w4", st4, 0);
        chk("R1 reset after stepping w8", st8, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        t_reset();
        t_seq4();
        t_period8();
        t_hold();
        t_seed();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule